// File: doc/BRIEF.md
# Virtual Partition ID Label Generator

This block produces the partition ID pair, one instruction-side and one data-side, that labels every memory request leaving a core. It selects a source register pair from the current privilege level and a few hypervisor controls. When virtual mapping is enabled for the chosen source, it translates each ID through a bank of mapping registers.

Level 0 normally takes its IDs from the level-0 source pair. A guest lock bit can redirect level 0 to the level-1 source pair instead. Level 1 always uses the level-1 pair. Levels 2 and 3 take a separate upper-level pair and never translate.

Each of the eight 64-bit mapping registers holds four 16-bit physical IDs, which gives 32 valid virtual IDs. All inputs are sampled on every clock edge, and the label appears one cycle later.

Top module: `pid_label_gen`

## Requirements
- R1: While reset is asserted, and for two cycles after it is released, both outputs are 0.
- R2: At privilege level 0, when the borrow condition of R3 is false, the IDs come from the level-0 source pair.
- R3: At privilege level 0, the level-1 source pair is used when the second-level layer is on, the trap-general bit is 0 and the guest lock bit is 1.
- R4: At privilege level 1 the level-1 source pair is always used, whatever the state of the guest lock bit.
- R5: When the level-1 pair is used, the layer is on and the level-1 map enable is 1, both IDs are translated. When that enable is 0, they pass through unchanged.
- R6: When level 0 borrows the level-1 pair, translation follows the level-1 map enable, and the level-0 map enable has no effect.
- R7: When level 0 uses its own pair, the layer is on and the level-0 map enable is 1, the IDs are translated. The enable is ignored, and no translation happens, when the host-extension bit and the trap-general bit are both 1.
- R8: Mapping register r sits at bits [64r+63:64r] of the bank port. Virtual ID v reads register v/4, bits [16(v%4)+15:16(v%4)].
- R9: A virtual ID of 32 or more translates to physical ID 0.
- R10: When the second-level layer is off, the guest lock bit and both map enables have no effect, and the level-0 and level-1 pairs pass through untranslated.
- R11: At privilege levels 2 and 3 the outputs equal the upper-level source pair, untranslated.
- R12: The outputs reflect the inputs sampled at the previous rising clock edge: exactly one cycle of latency.
- R13: The instruction-side and data-side IDs are translated independently, each with its own bank lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| lvl2_on | input | 1 | Second-level layer enabled in the current security state |
| host_ext | input | 1 | Host-extension bit |
| tge_bit | input | 1 | Trap-general-exceptions bit |
| guest_lock | input | 1 | Level 0 borrows the level-1 source pair |
| map_en_l0 | input | 1 | Virtual mapping enable for the level-0 source |
| map_en_l1 | input | 1 | Virtual mapping enable for the level-1 source |
| src0_iid | input | 16 | Level-0 instruction-side ID |
| src0_did | input | 16 | Level-0 data-side ID |
| src1_iid | input | 16 | Level-1 instruction-side ID |
| src1_did | input | 16 | Level-1 data-side ID |
| top_iid | input | 16 | Upper-level (levels 2 and 3) instruction-side ID |
| top_did | input | 16 | Upper-level data-side ID |
| map_bank | input | 512 | Eight concatenated 64-bit mapping registers |
| phys_iid | output | 16 | Physical instruction-side label |
| phys_did | output | 16 | Physical data-side label |

## Verification
The only internal state is the output register pair and the reset synchronizer. A wrong source choice or a wrong map-enable decision therefore shows up on the outputs one cycle after the inputs that cause it. A wrong lookup shows as an ID taken from the neighbouring field, or from the wrong register in the bank, on the next cycle. Each bank field is loaded with a distinct value that is never a valid virtual ID, so any such error produces a value that cannot be confused with the correct one. A stuck synchronizer shows as outputs that stay 0 after reset is released, or that leave 0 too early.

// File: rtl/pid_pkg.sv
package pid_pkg;

  // Which source pair feeds the label for the current request
  typedef enum logic [1:0] {
    SRC_L0  = 2'd0,
    SRC_L1  = 2'd1,
    SRC_TOP = 2'd2
  } pid_src_e;

  typedef struct packed {
    pid_src_e sel;
    logic     map_on;
  } pid_route_t;

endpackage

// File: rtl/pid_src_sel.sv
module pid_src_sel
  import pid_pkg::*;
(
  input  logic [1:0] priv_lvl,
  input  logic       lvl2_on,
  input  logic       host_ext,
  input  logic       tge_bit,
  input  logic       guest_lock,
  input  logic       map_en_l0,
  input  logic       map_en_l1,
  output pid_route_t route
);

  logic borrow;
  logic host_mode;

  // Level 0 takes the level-1 pair only with the layer on, trap-general clear and lock set
  assign borrow    = (priv_lvl == 2'd0) && lvl2_on && !tge_bit && guest_lock;
  assign host_mode = host_ext && tge_bit;

  always_comb begin
    route.sel    = SRC_TOP;
    route.map_on = 1'b0;
    unique case (priv_lvl)
      2'd0: begin
        if (borrow) begin
          route.sel    = SRC_L1;
          route.map_on = lvl2_on && map_en_l1;
        end else begin
          route.sel    = SRC_L0;
          route.map_on = lvl2_on && map_en_l0 && !host_mode;
        end
      end
      2'd1: begin
        route.sel    = SRC_L1;
        route.map_on = lvl2_on && map_en_l1;
      end
      default: begin
        route.sel    = SRC_TOP;
        route.map_on = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pid_vmap.sv
module pid_vmap #(
  parameter int unsigned PID_W    = 16,
  parameter int unsigned MAP_REGS = 8,
  parameter int unsigned FIELDS   = 4
) (
  input  logic [PID_W-1:0]                 vid,
  input  logic [MAP_REGS*FIELDS*PID_W-1:0] bank,
  output logic [PID_W-1:0]                 pid
);

  localparam int unsigned REG_W = FIELDS * PID_W;
  localparam int unsigned NUM_V = MAP_REGS * FIELDS;
  localparam int unsigned FLD_W = (FIELDS > 1) ? $clog2(FIELDS) : 1;
  localparam int unsigned RSL_W = (MAP_REGS > 1) ? $clog2(MAP_REGS) : 1;
  localparam int unsigned IDX_W = FLD_W + RSL_W;

  logic [REG_W-1:0] regs   [MAP_REGS];
  logic [PID_W-1:0] fields [MAP_REGS][FIELDS];
  logic [RSL_W-1:0] reg_sel;
  logic [FLD_W-1:0] fld_sel;
  logic             in_range;
  logic [IDX_W-1:0] idx;

  // Break the flat bank into registers and then into fields
  for (genvar r = 0; r < MAP_REGS; r++) begin : g_reg
    assign regs[r] = bank[r*REG_W +: REG_W];
    for (genvar f = 0; f < FIELDS; f++) begin : g_fld
      assign fields[r][f] = regs[r][f*PID_W +: PID_W];
    end
  end

  assign in_range = (vid < PID_W'(NUM_V));
  assign idx      = vid[IDX_W-1:0];
  assign fld_sel  = idx[FLD_W-1:0];
  assign reg_sel  = idx[IDX_W-1:FLD_W];

  always_comb begin
    if (in_range) begin
      pid = fields[reg_sel][fld_sel];
    end else begin
      pid = '0;
    end
  end

endmodule

// File: rtl/pid_label_gen.sv
module pid_label_gen
  import pid_pkg::*;
#(
  parameter int unsigned PID_W    = 16,
  parameter int unsigned MAP_REGS = 8,
  parameter int unsigned FIELDS   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       priv_lvl,
  input  logic                             lvl2_on,
  input  logic                             host_ext,
  input  logic                             tge_bit,
  input  logic                             guest_lock,
  input  logic                             map_en_l0,
  input  logic                             map_en_l1,
  input  logic [PID_W-1:0]                 src0_iid,
  input  logic [PID_W-1:0]                 src0_did,
  input  logic [PID_W-1:0]                 src1_iid,
  input  logic [PID_W-1:0]                 src1_did,
  input  logic [PID_W-1:0]                 top_iid,
  input  logic [PID_W-1:0]                 top_did,
  input  logic [MAP_REGS*FIELDS*PID_W-1:0] map_bank,
  output logic [PID_W-1:0]                 phys_iid,
  output logic [PID_W-1:0]                 phys_did
);

  localparam int unsigned NSIDE = 2;  // instruction side, data side

  logic [1:0]       rst_sync;
  logic             rst_q_n;
  pid_route_t       route;
  logic [PID_W-1:0] raw_id  [NSIDE];
  logic [PID_W-1:0] map_id  [NSIDE];
  logic [PID_W-1:0] nxt_id  [NSIDE];
  logic [PID_W-1:0] lab_q   [NSIDE];

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync[1];

  pid_src_sel u_sel (
    .priv_lvl  (priv_lvl),
    .lvl2_on   (lvl2_on),
    .host_ext  (host_ext),
    .tge_bit   (tge_bit),
    .guest_lock(guest_lock),
    .map_en_l0 (map_en_l0),
    .map_en_l1 (map_en_l1),
    .route     (route)
  );

  always_comb begin
    unique case (route.sel)
      SRC_L0: begin
        raw_id[0] = src0_iid;
        raw_id[1] = src0_did;
      end
      SRC_L1: begin
        raw_id[0] = src1_iid;
        raw_id[1] = src1_did;
      end
      default: begin
        raw_id[0] = top_iid;
        raw_id[1] = top_did;
      end
    endcase
  end

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    pid_vmap #(
      .PID_W   (PID_W),
      .MAP_REGS(MAP_REGS),
      .FIELDS  (FIELDS)
    ) u_map (
      .vid (raw_id[s]),
      .bank(map_bank),
      .pid (map_id[s])
    );

    // Next-state selection
    always_comb begin
      nxt_id[s] = route.map_on ? map_id[s] : raw_id[s];
    end

    // Label register
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        lab_q[s] <= '0;
      end else begin
        lab_q[s] <= nxt_id[s];
      end
    end
  end

  assign phys_iid = lab_q[0];
  assign phys_did = lab_q[1];

endmodule

// File: rtl/pid_label_chk.sv
module pid_label_chk #(
  parameter int unsigned PID_W    = 16,
  parameter int unsigned MAP_REGS = 8,
  parameter int unsigned FIELDS   = 4
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic [1:0]       priv_lvl,
  input logic             lvl2_on,
  input logic             host_ext,
  input logic             tge_bit,
  input logic             map_en_l1,
  input logic [PID_W-1:0] src0_iid,
  input logic [PID_W-1:0] src0_did,
  input logic [PID_W-1:0] src1_iid,
  input logic [PID_W-1:0] src1_did,
  input logic [PID_W-1:0] top_iid,
  input logic [PID_W-1:0] top_did,
  input logic [PID_W-1:0] phys_iid,
  input logic [PID_W-1:0] phys_did
);

  localparam int unsigned NUM_V = MAP_REGS * FIELDS;

  // R5: level 1 with the level-1 enable clear passes through
  p_l1_pass_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (priv_lvl == 2'd1 && !map_en_l1) |=>
      (phys_iid == $past(src1_iid) && phys_did == $past(src1_did)));

  // R11: levels 2 and 3 pass the upper pair through
  p_upper_pass_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (priv_lvl >= 2'd2) |=>
      (phys_iid == $past(top_iid) && phys_did == $past(top_did)));

  // R10: with the layer off, level 0 uses its own pair untranslated
  p_layer_off_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (priv_lvl == 2'd0 && !lvl2_on) |=>
      (phys_iid == $past(src0_iid) && phys_did == $past(src0_did)));

  // R7: host mode ignores the level-0 enable
  p_host_ignore_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (priv_lvl == 2'd0 && lvl2_on && host_ext && tge_bit) |=>
      (phys_iid == $past(src0_iid) && phys_did == $past(src0_did)));

  // R9: out-of-range virtual ID translates to 0
  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (priv_lvl == 2'd1 && lvl2_on && map_en_l1 && src1_iid >= PID_W'(NUM_V)) |=>
      (phys_iid == '0));

endmodule

bind pid_label_gen pid_label_chk #(
  .PID_W   (PID_W),
  .MAP_REGS(MAP_REGS),
  .FIELDS  (FIELDS)
) u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .priv_lvl (priv_lvl),
  .lvl2_on  (lvl2_on),
  .host_ext (host_ext),
  .tge_bit  (tge_bit),
  .map_en_l1(map_en_l1),
  .src0_iid (src0_iid),
  .src0_did (src0_did),
  .src1_iid (src1_iid),
  .src1_did (src1_did),
  .top_iid  (top_iid),
  .top_did  (top_did),
  .phys_iid (phys_iid),
  .phys_did (phys_did)
);

// File: tb/pid_label_gen_test.sv
module pid_label_gen_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   priv_lvl;
  logic         lvl2_on, host_ext, tge_bit, guest_lock, map_en_l0, map_en_l1;
  logic [15:0]  src0_iid, src0_did, src1_iid, src1_did, top_iid, top_did;
  logic [511:0] map_bank;
  logic [15:0]  phys_iid, phys_did;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pid_label_gen uut (
    .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .lvl2_on(lvl2_on),
    .host_ext(host_ext), .tge_bit(tge_bit), .guest_lock(guest_lock),
    .map_en_l0(map_en_l0), .map_en_l1(map_en_l1),
    .src0_iid(src0_iid), .src0_did(src0_did), .src1_iid(src1_iid),
    .src1_did(src1_did), .top_iid(top_iid), .top_did(top_did),
    .map_bank(map_bank), .phys_iid(phys_iid), .phys_did(phys_did)
  );

  // Expected translation: distinct values, none below 32
  function automatic logic [15:0] exp_map(input logic [15:0] v);
    if (v < 16'd32) return 16'h4000 + v * 16'd273;
    return 16'h0000;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic defaults();
    priv_lvl = 2'd0; lvl2_on = 1'b0; host_ext = 1'b0; tge_bit = 1'b0;
    guest_lock = 1'b0; map_en_l0 = 1'b0; map_en_l1 = 1'b0;
    src0_iid = 16'd3;  src0_did = 16'd5;
    src1_iid = 16'd9;  src1_did = 16'd14;
    top_iid  = 16'hBEEF; top_did = 16'hCAFE;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    defaults();
    priv_lvl = 2'd3;
    repeat (3) step();
    chk("R1 iid in reset", phys_iid, 16'h0);
    chk("R1 did in reset", phys_did, 16'h0);
    rst_n = 1'b1;
    step();
    chk("R1 iid just after release", phys_iid, 16'h0);
    repeat (3) step();
    chk("R1 exit to upper pair", phys_iid, 16'hBEEF);
  endtask

  task automatic t_lvl0_plain();
    defaults(); lvl2_on = 1'b1; tge_bit = 1'b1; guest_lock = 1'b1;
    step();
    chk("R2 tge blocks borrow iid", phys_iid, 16'd3);
    chk("R2 tge blocks borrow did", phys_did, 16'd5);
    defaults(); lvl2_on = 1'b1;
    step();
    chk("R2 lock clear iid", phys_iid, 16'd3);
  endtask

  task automatic t_borrow();
    defaults(); lvl2_on = 1'b1; guest_lock = 1'b1;
    step();
    chk("R3 borrow iid", phys_iid, 16'd9);
    chk("R3 borrow did", phys_did, 16'd14);
  endtask

  task automatic t_lvl1();
    defaults(); priv_lvl = 2'd1; lvl2_on = 1'b1; guest_lock = 1'b0;
    step();
    chk("R4 level1 untranslated", phys_iid, 16'd9);
    map_en_l1 = 1'b1;
    step();
    chk("R5 level1 mapped iid", phys_iid, exp_map(16'd9));
    chk("R5 level1 mapped did", phys_did, exp_map(16'd14));
  endtask

  task automatic t_borrow_en();
    defaults(); lvl2_on = 1'b1; guest_lock = 1'b1; map_en_l0 = 1'b1;
    step();
    chk("R6 l0 enable no effect on borrow", phys_iid, 16'd9);
    map_en_l0 = 1'b0; map_en_l1 = 1'b1;
    step();
    chk("R6 l1 enable maps borrow", phys_iid, exp_map(16'd9));
  endtask

  task automatic t_map_l0();
    defaults(); lvl2_on = 1'b1; map_en_l0 = 1'b1;
    step();
    chk("R7 level0 mapped iid", phys_iid, exp_map(16'd3));
    chk("R7 level0 mapped did", phys_did, exp_map(16'd5));
    host_ext = 1'b1; tge_bit = 1'b1;
    step();
    chk("R7 host mode ignores enable", phys_iid, 16'd3);
    host_ext = 1'b1; tge_bit = 1'b0;
    step();
    chk("R7 host ext alone still maps", phys_iid, exp_map(16'd3));
  endtask

  task automatic t_layout();
    defaults(); priv_lvl = 2'd1; lvl2_on = 1'b1; map_en_l1 = 1'b1;
    for (int v = 0; v < 32; v++) begin
      src1_iid = 16'(v);
      src1_did = 16'(31 - v);
      step();
      chk("R8 field layout iid", phys_iid, exp_map(16'(v)));
      chk("R13 independent did", phys_did, exp_map(16'(31 - v)));
    end
  endtask

  task automatic t_oob();
    defaults(); priv_lvl = 2'd1; lvl2_on = 1'b1; map_en_l1 = 1'b1;
    src1_iid = 16'd32; src1_did = 16'd4;
    step();
    chk("R9 id 32 gives 0", phys_iid, 16'h0);
    chk("R13 other side unaffected", phys_did, exp_map(16'd4));
    src1_iid = 16'hFFFF;
    step();
    chk("R9 id ffff gives 0", phys_iid, 16'h0);
  endtask

  task automatic t_layer_off();
    defaults(); guest_lock = 1'b1; map_en_l0 = 1'b1; map_en_l1 = 1'b1;
    step();
    chk("R10 no borrow, no map at level0", phys_iid, 16'd3);
    priv_lvl = 2'd1;
    step();
    chk("R10 no map at level1", phys_did, 16'd14);
  endtask

  task automatic t_upper();
    defaults(); lvl2_on = 1'b1; map_en_l0 = 1'b1; map_en_l1 = 1'b1;
    top_iid = 16'd2; top_did = 16'd7;
    priv_lvl = 2'd2;
    step();
    chk("R11 level2 iid", phys_iid, 16'd2);
    chk("R11 level2 did", phys_did, 16'd7);
    priv_lvl = 2'd3;
    step();
    chk("R11 level3 iid", phys_iid, 16'd2);
  endtask

  task automatic t_latency();
    defaults(); priv_lvl = 2'd2; top_iid = 16'h1111;
    step();
    top_iid = 16'h2222;
    #5;
    chk("R12 holds before edge", phys_iid, 16'h1111);
    step();
    chk("R12 updates after edge", phys_iid, 16'h2222);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) begin
      for (int f = 0; f < 4; f++) begin
        map_bank[r*64 + f*16 +: 16] = exp_map(16'(r*4 + f));
      end
    end
    t_reset();
    t_lvl0_plain();
    t_borrow();
    t_lvl1();
    t_borrow_en();
    t_map_l0();
    t_layout();
    t_oob();
    t_layer_off();
    t_upper();
    t_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule